// File: doc/BRIEF.md
# Access Violation Event Collector

This block gathers fault events from a large set of protected targets into banked, sticky pending registers and raises a single interrupt line. Every protected target carries a numeric ID. Two fault classes report into one shared ID space. The first class is a rights violation: an access that failed context-ID, security-level or privilege filtering. The second class is a security error: an access to a target that is held in reset or whose clock is gated. That second class also returns an error response on the bus to the initiator in the same cycle as the event.

Software sees the pending flags as 32-bit banks. Target ID n lives in bank n/32 at bit n%32. Software clears flags by writing ones into a bank, and gates the interrupt with a global enable bit. For each bank a read-only word gives the lowest pending ID in that bank, which saves a bit scan when several faults are outstanding. The block does not decide access rights, does not control clocks and has no panic policy. It only records and reports.

Top module: `viol_evt_collector`

## Requirements
- R1: An event with target ID n sets bit (n mod 32) of pending bank (n / 32). Pending bank k is read at word address k (k = 0..4 for 160 targets). For example, ID 156 reads as 0x10000000 at address 4.
- R2: A pulse on `rv_valid` records a rights violation for `rv_id` in the pending flags and produces no bus error.
- R3: A pulse on `se_valid` records a security error for `se_id` in the pending flags. `bus_err` is high in exactly the cycles in which `se_valid` is high, combinationally, and low otherwise.
- R4: Both classes use the same ID numbering. The same ID from either source sets the same bit. Two events in one cycle, on the same or different IDs, are both recorded.
- R5: Pending bits are sticky. Events that arrive while the interrupt is disabled accumulate, and all of them stay visible on read.
- R6: A register write to pending bank k clears exactly the bits that are 1 in the write data. Bits written as 0 are unchanged.
- R7: When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: `irq` is a registered level. After each clock edge it equals (enable AND any pending bit), using the values held before that edge. The enable is bit 0 of the control word at address 10; it resets to 0 and is read back there.
- R9: The lowest-ID word for bank k is at address 5+k. Bit 31 is a valid flag, and bits 7:0 hold the global ID of the lowest pending bit in bank k. The whole word reads 0 when the bank is empty.
- R10: A read returns its data on `reg_rdata` after the next clock edge, and the data holds until the next read. Addresses 11..15 read as 0. Writes to lowest-ID words or to unmapped addresses change nothing. Event IDs of 160 or above are ignored.
- R11: After reset all pending bits are 0, the enable is 0, `irq` is 0 and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rv_valid | input | 1 | Rights-violation event strobe |
| rv_id | input | 8 | Target ID of the rights violation |
| se_valid | input | 1 | Security-error event strobe (reset or gated target) |
| se_id | input | 8 | Target ID of the security error |
| bus_err | output | 1 | Error response to the initiator, same cycle as `se_valid` |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| irq | output | 1 | Registered interrupt level |

## Verification
The assertions assume that reset is held low for at least two clock edges, so that every history term they use starts from a cleared state. They also assume that `reg_rd` and `reg_wr` are never high in the same cycle. The stimulus drives at most one register operation per cycle and starts with a multi-cycle reset. Its random IDs include values above the last target, so the ignore rule is exercised without breaking any assumption. Random write-1 masks and enable toggles are mixed with events in the same cycles, so that set-versus-clear collisions happen naturally.

// File: rtl/viol_evt_pkg.sv
// Package: shared constants, types and helpers for the violation event collector.
// Assumes banks are always 32 bits wide, matching the register data width.
package viol_evt_pkg;

    localparam int BANK_W = 32;

    typedef logic [BANK_W-1:0] word_t;

    // Integer ceiling division used to size the bank count.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/viol_id_decode.sv
// Module: turns one (valid, id) event strobe into a one-hot vector across all banks.
// Assumes ID_W <= 31; ids at or above LIMIT produce an all-zero vector.
module viol_id_decode #(
    parameter int ID_W     = 8,
    parameter int NUM_BITS = 160,
    parameter int LIMIT    = 160
) (
    input  logic                evt_vld,
    input  logic [ID_W-1:0]     evt_id,
    output logic [NUM_BITS-1:0] evt_hot
);

    // One comparator per bit position; positions past LIMIT stay zero.
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
        if (i < LIMIT) begin : g_live
            assign evt_hot[i] = evt_vld && (32'(evt_id) == 32'(i));
        end else begin : g_dead
            assign evt_hot[i] = 1'b0;
        end
    end

endmodule

// File: rtl/viol_pend_bank.sv
// Module: one bank of sticky pending flags with write-1-to-clear; set wins over clear.
// Assumes set_vec and clr_vec are single-cycle pulses; bits above LIVE never set.
module viol_pend_bank #(
    parameter int BANK_W = 32,
    parameter int LIVE   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] set_vec,
    input  logic [BANK_W-1:0] clr_vec,
    output logic [BANK_W-1:0] pend_q
);

    localparam logic [BANK_W-1:0] LIVE_MASK = (LIVE >= BANK_W) ? {BANK_W{1'b1}}
                                            : BANK_W'((64'd1 << LIVE) - 64'd1);

    // Update the pending flags: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= ((pend_q & ~clr_vec) | set_vec) & LIVE_MASK;
        end
    end

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend_q) & $past(pend_q) & ~$past(clr_vec)) == '0);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & LIVE_MASK)) |=>
            ((pend_q & $past(set_vec & LIVE_MASK)) == $past(set_vec & LIVE_MASK)));

endmodule

// File: rtl/viol_low_find.sv
// Module: priority encoder giving the index of the lowest set bit of a vector.
// Assumes W is a power of two; idx is 0 when no bit is set.
module viol_low_find #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     vec,
    output logic             vld,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        vld = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    // R9
    low_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> vec[idx]);

    // R9
    low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ((vec & ((W'(1) << idx) - W'(1))) == '0));

endmodule

// File: rtl/viol_evt_collector.sv
// Module: top of the violation event collector. Two event classes share one ID space,
// feed banked sticky pending flags, and drive a registered interrupt. A small register
// port gives pending banks (W1C), lowest-ID words and a control word, with 1-cycle reads.
// Assumes reg_rd and reg_wr are never high together, and that NUM_TARGETS < 2**ID_W.
module viol_evt_collector
    import viol_evt_pkg::*;
#(
    parameter int NUM_TARGETS = 160,
    parameter int ID_W        = 8,
    parameter int ADDR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rv_valid,
    input  logic [ID_W-1:0]   rv_id,
    input  logic              se_valid,
    input  logic [ID_W-1:0]   se_id,
    output logic              bus_err,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    localparam int NB        = ceil_div(NUM_TARGETS, BANK_W);
    localparam int ALL_W     = NB * BANK_W;
    localparam int IDX_W     = $clog2(BANK_W);
    localparam int LOW_BASE  = NB;
    localparam int CTRL_ADDR = 2 * NB;

    logic [ALL_W-1:0] rv_hot;
    logic [ALL_W-1:0] se_hot;
    logic [ALL_W-1:0] set_all;
    logic [ALL_W-1:0] pend_all;
    word_t            pend_arr [NB];
    word_t            low_arr  [NB];
    logic             en_q;
    word_t            rd_mux;

    // The gated-target class answers the initiator with an error in the same cycle.
    assign bus_err = se_valid;

    viol_id_decode #(.ID_W(ID_W), .NUM_BITS(ALL_W), .LIMIT(NUM_TARGETS)) u_rv_dec (
        .evt_vld (rv_valid),
        .evt_id  (rv_id),
        .evt_hot (rv_hot)
    );

    viol_id_decode #(.ID_W(ID_W), .NUM_BITS(ALL_W), .LIMIT(NUM_TARGETS)) u_se_dec (
        .evt_vld (se_valid),
        .evt_id  (se_id),
        .evt_hot (se_hot)
    );

    assign set_all = rv_hot | se_hot;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int LIVE = (NUM_TARGETS - b * BANK_W >= BANK_W) ? BANK_W
                            : (NUM_TARGETS - b * BANK_W);
        word_t            clr_vec;
        logic             low_vld;
        logic [IDX_W-1:0] low_idx;

        // Decode a write-1-to-clear aimed at this bank.
        always_comb begin
            clr_vec = '0;
            if (reg_wr && (reg_addr == ADDR_W'(b))) clr_vec = reg_wdata;
        end

        viol_pend_bank #(.BANK_W(BANK_W), .LIVE(LIVE)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_all[b*BANK_W +: BANK_W]),
            .clr_vec (clr_vec),
            .pend_q  (pend_arr[b])
        );

        viol_low_find #(.W(BANK_W), .IDX_W(IDX_W)) u_low (
            .clk   (clk),
            .rst_n (rst_n),
            .vec   (pend_arr[b]),
            .vld   (low_vld),
            .idx   (low_idx)
        );

        // Form the lowest-ID word: valid in bit 31, global ID in the low bits.
        always_comb begin
            low_arr[b] = '0;
            if (low_vld) begin
                low_arr[b][31]       = 1'b1;
                low_arr[b][ID_W-1:0] = ID_W'(b * BANK_W + int'(low_idx));
            end
        end

        assign pend_all[b*BANK_W +: BANK_W] = pend_arr[b];
    end

    // Hold the global interrupt enable written through the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR))) begin
            en_q <= reg_wdata[0];
        end
    end

    // Register the interrupt level from enable and the OR of all pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= en_q & (|pend_all);
        end
    end

    // Select the word addressed by a read.
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NB; k++) begin
            if (reg_addr == ADDR_W'(k))            rd_mux = pend_arr[k];
            if (reg_addr == ADDR_W'(LOW_BASE + k)) rd_mux = low_arr[k];
        end
        if (reg_addr == ADDR_W'(CTRL_ADDR)) rd_mux = {31'd0, en_q};
    end

    // Capture read data one cycle after the strobe and hold it until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en_q));

    // R10
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == ADDR_W'(CTRL_ADDR))) |=> (reg_rdata == {31'd0, $past(en_q)}));

    // R3
    bus_err_only_se_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rv_valid && !se_valid) |-> !bus_err);

endmodule

// File: tb/viol_evt_collector_test.sv
`timescale 1ns/1ps
module viol_evt_collector_test;
    import viol_evt_pkg::*;

    localparam int NT   = 160;
    localparam int NB   = 5;
    localparam int CTRL = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rv_valid = 1'b0;
    logic [7:0]  rv_id = '0;
    logic        se_valid = 1'b0;
    logic [7:0]  se_id = '0;
    logic        bus_err;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [NT-1:0] m_pend = '0;
    logic          m_en = 1'b0;
    logic          m_irq = 1'b0;

    always #2 clk = ~clk;

    viol_evt_collector uut (
        .clk, .rst_n, .rv_valid, .rv_id, .se_valid, .se_id, .bus_err,
        .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata, .irq
    );

    task automatic chk(input string req, input word_t act, input word_t exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic word_t exp_read(input int a);
        word_t w = '0;
        if (a < NB) begin
            w = m_pend[a*32 +: 32];
        end else if (a < 2 * NB) begin
            for (int i = 31; i >= 0; i--) begin
                if (m_pend[(a - NB) * 32 + i]) w = 32'h8000_0000 | word_t'((a - NB) * 32 + i);
            end
        end else if (a == CTRL) begin
            w = {31'd0, m_en};
        end
        return w;
    endfunction

    // Model of one clock edge: interrupt from old state, then clears, then sets.
    task automatic model_edge(input logic rv, input int rvi, input logic se, input int sei,
                              input logic wr, input int wa, input word_t wd);
        m_irq = m_en & (|m_pend);
        if (wr && wa < NB) m_pend[wa*32 +: 32] = m_pend[wa*32 +: 32] & ~wd;
        if (wr && wa == CTRL) m_en = wd[0];
        if (rv && rvi < NT) m_pend[rvi] = 1'b1;
        if (se && sei < NT) m_pend[sei] = 1'b1;
    endtask

    task automatic cyc(input logic rv, input int rvi, input logic se, input int sei,
                       input logic wr, input int wa, input word_t wd);
        @(negedge clk);
        rv_valid = rv; rv_id = 8'(rvi); se_valid = se; se_id = 8'(sei);
        reg_wr = wr; reg_addr = 4'(wa); reg_wdata = wd;
        #1;
        chk("R3 bus_err", word_t'(bus_err), word_t'(se));
        @(posedge clk);
        model_edge(rv, rvi, se, sei, wr, wa, wd);
        #1;
        rv_valid = 0; se_valid = 0; reg_wr = 0;
        chk("R8 irq", word_t'(irq), word_t'(m_irq));
    endtask

    task automatic rd(input string req, input int a);
        word_t e;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'(a);
        e = exp_read(a);
        @(posedge clk);
        model_edge(0, 0, 0, 0, 0, 0, '0);
        #1;
        reg_rd = 1'b0;
        chk(req, reg_rdata, e);
        chk("R8 irq", word_t'(irq), word_t'(m_irq));
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, '0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11 reset state
        #1;
        chk("R11 irq", word_t'(irq), 0);
        chk("R11 rdata", reg_rdata, 0);
        rd("R11 bank0", 0);
        rd("R11 ctrl", CTRL);

        // R1 R2: rights violation on ID 156
        cyc(1, 156, 0, 0, 0, 0, '0);
        rd("R1 R2 id156", 4);
        // R3: security error on ID 114
        cyc(0, 0, 1, 114, 0, 0, '0);
        rd("R3 id114", 3);
        // R4: same ID from both classes, and two IDs in one cycle
        cyc(1, 40, 1, 40, 0, 0, '0);
        rd("R4 same id", 1);
        cyc(1, 3, 1, 7, 0, 0, '0);
        rd("R4 two ids", 0);
        // R5: all accumulated while disabled, no interrupt
        chk("R5 irq off", word_t'(irq), 0);
        for (int a = 0; a < NB; a++) rd("R5 accumulate", a);
        // R8: enable, interrupt follows one edge later
        cyc(0, 0, 0, 0, 1, CTRL, 32'h1);
        chk("R8 irq lag", word_t'(irq), 0);
        idle();
        chk("R8 irq on", word_t'(irq), 1);
        // R9: lowest-ID words
        rd("R9 low bank0", NB + 0);
        rd("R9 low bank2 empty", NB + 2);
        rd("R9 low bank4", NB + 4);
        // R6: clear one bit only
        cyc(0, 0, 0, 0, 1, 0, 32'h8);
        rd("R6 w1c", 0);
        rd("R6 R9 low moves", NB + 0);
        // R7: set and clear on the same bit
        cyc(1, 7, 0, 0, 1, 0, 32'h80);
        rd("R7 set wins", 0);
        // R10: out of range IDs, writes to read-only and unmapped words
        cyc(1, 165, 1, 200, 1, NB + 1, 32'hFFFF_FFFF);
        cyc(0, 0, 0, 0, 1, 13, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) rd("R10 map", a);
        // R8: clearing everything drops the interrupt
        for (int a = 0; a < NB; a++) cyc(0, 0, 0, 0, 1, a, 32'hFFFF_FFFF);
        idle();
        chk("R8 irq off", word_t'(irq), 0);

        // Random mix: events, W1C, enable toggles and reads (R1..R10)
        for (int it = 0; it < 600; it++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k < 6) begin
                cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 175)),
                    1'($urandom_range(0, 1)), int'($urandom_range(0, 175)),
                    1'(k < 3), (k == 0) ? CTRL : int'($urandom_range(0, NB - 1)),
                    $urandom() & $urandom());
            end else begin
                rd("R1 R5 R6 R9 random read", int'($urandom_range(0, 15)));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule